// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Reporting

This block receives asynchronous serial frames on one input line and turns them into bytes. Each frame has a start bit (low), then the data bits with the least significant bit first, then a parity bit if one is configured, then a stop bit (high). The received byte goes into a receive buffer register. A three-bit status register records parity, framing and overrun errors for the most recent frame. Two single-cycle interrupt pulses report the frame to software. One pulse reports an error and the other reports completion. For any frame, the error pulse always comes before the completion pulse.

Bit timing comes from a sample-enable tick input, at `TICKS_PER_BIT` ticks per bit (16 by default). Each bit is sampled at its midpoint. Software reads the block through a plain register-read port, which has no valid/ready handshake:

- `rd_sel` chooses what `rd_data` shows, combinationally.
- `rd_sel`=0 shows the status register, zero-extended. Reading it has no side effects.
- `rd_sel`=1 shows the buffer. Asserting `rd_en` while `rd_sel`=1 counts as a buffer read. A buffer read clears the status register and the buffer-full flag.

Software is expected to read the status register first and then read the buffer. The block exerts no back-pressure: if a frame arrives while the buffer is still full, the new byte overwrites the old one and the frame is flagged as an overrun.

Top module: `uart_rx_err`

## Requirements
- R1: A frame is a low start bit, then `DATA_W` data bits with the LSB first, then an optional parity bit, then a stop bit. When the stop bit is sampled, the data bits are written to the buffer and `buf_full` is set to 1.
- R2: `par_mode` selects the parity: 2'b00 means no parity bit, 2'b01 even, 2'b10 odd, and 2'b11 means a parity bit is present but not checked. A parity mismatch in even or odd mode sets status bit 2 (value 0x04). This flag is set as soon as the parity bit is sampled.
- R3: A stop bit that is sampled low sets status bit 1 (value 0x02).
- R4: A frame that completes while `buf_full` is 1, and not in a cycle with a buffer read, sets status bit 0 (value 0x01). The new byte overwrites the buffer, and `buf_full` stays at 1.
- R5: `irq_err` pulses for one cycle for each error event. A parity error gives its pulse at the parity-bit sample. A framing or overrun error gives its pulse at the stop-bit sample. A frame with both a parity error and a stop-time error therefore gives two pulses.
- R6: `irq_done` is a single-cycle pulse for each completed frame. It never coincides with `irq_err`, and it comes strictly after every `irq_err` pulse of the same frame.
- R7: When `err_mask` is 1 and a frame has any error, no `irq_done` pulse is given for that frame. The error pulses are still given.
- R8: A buffer read (`rd_en`=1 with `rd_sel`=1) clears the status register to 0 and clears `buf_full`. `buf_full` is cleared by nothing else. A status read (`rd_en`=1 with `rd_sel`=0) changes nothing.
- R9: When a new frame completes, its own error result replaces the status register. Flags that belonged to the previous frame are dropped.
- R10: A start bit that is no longer low at its midpoint is rejected as noise. The receiver returns to idle, and no byte, status change or interrupt results.
- R11: After reset, the status register, the buffer, `buf_full`, `irq_err` and `irq_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Sample enable, `TICKS_PER_BIT` pulses per bit time |
| rxd | input | 1 | Serial receive line; idles high |
| par_mode | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 present but not checked |
| err_mask | input | 1 | When 1, suppresses `irq_done` for frames that have an error |
| rd_en | input | 1 | Read strobe; has an effect only when `rd_sel`=1 (buffer read) |
| rd_sel | input | 1 | 0 selects the status register, 1 selects the buffer |
| rd_data | output | DATA_W | Selected register; status is zero-extended, bit 2 parity, bit 1 framing, bit 0 overrun |
| buf_full | output | 1 | The buffer holds a byte that has not been read |
| irq_err | output | 1 | Reception-error pulse |
| irq_done | output | 1 | Reception-complete pulse |

## Verification
The bench builds the block with `TICKS_PER_BIT`=16, `DATA_W`=8 and `SYNC_STAGES`=2, and gives one tick every fourth clock, so one bit lasts 64 clocks. At this rate the whole frame sequence is short. Every parity mode can be reached, including a frame with both a parity error and a framing error. Overruns can be forced by leaving the buffer unread between frames. A start glitch of three ticks, shorter than the eight-tick half-bit check, exercises noise rejection.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE   = 2'b00,
    PAR_EVEN   = 2'b01,
    PAR_ODD    = 2'b10,
    PAR_IGNORE = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rx_state_e;

  localparam int STAT_W = 3;
  localparam int ST_OVR = 0;
  localparam int ST_FRM = 1;
  localparam int ST_PAR = 2;

  // ones_odd is the XOR of the data bits; returns 1 on a checked mismatch
  function automatic logic parity_bad(input par_mode_e mode, input logic ones_odd,
                                      input logic pbit);
    case (mode)
      PAR_EVEN: parity_bad = ones_odd ^ pbit;
      PAR_ODD:  parity_bad = ~(ones_odd ^ pbit);
      default:  parity_bad = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic [1:0]        par_mode,
  output logic              ev_par,
  output logic              ev_done,
  output logic              par_err,
  output logic              frm_err,
  output logic [DATA_W-1:0] data
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID   = CNT_W'(TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] DLAST = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              perr_q, ferr_q, ev_par_q, ev_done_q;
  logic              at_mid, at_bit;
  par_mode_e         mode;

  assign at_mid = (cnt_q == MID);
  assign at_bit = (cnt_q == LAST);
  assign mode   = par_mode_e'(par_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      ev_par_q  <= 1'b0;
      ev_done_q <= 1'b0;
    end else begin
      ev_par_q  <= 1'b0;
      ev_done_q <= 1'b0;
      if (tick) begin
        case (state_q)
          RX_IDLE: begin
            if (!rx) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (at_mid) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              perr_q  <= 1'b0;
              state_q <= rx ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (at_bit) begin
              cnt_q   <= '0;
              shift_q <= {rx, shift_q[DATA_W-1:1]};
              if (idx_q == DLAST) state_q <= (mode == PAR_NONE) ? RX_STOP : RX_PARITY;
              else                idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_PARITY: begin
            if (at_bit) begin
              cnt_q    <= '0;
              perr_q   <= parity_bad(mode, ^shift_q, rx);
              ev_par_q <= 1'b1;
              state_q  <= RX_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (at_bit) begin
              cnt_q     <= '0;
              ferr_q    <= !rx;
              ev_done_q <= 1'b1;
              state_q   <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign ev_par  = ev_par_q;
  assign ev_done = ev_done_q;
  assign par_err = perr_q;
  assign frm_err = ferr_q;
  assign data    = shift_q;
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_par,
  input  logic              ev_done,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic [DATA_W-1:0] data,
  input  logic              err_mask,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic [STAT_W-1:0] status,
  output logic              irq_err,
  output logic              irq_done
);
  logic [DATA_W-1:0] buf_q;
  logic [STAT_W-1:0] stat_q;
  logic              full_q, ierr_q, idone_q, pend_q;
  logic              buf_rd, ovr;
  logic [STAT_W-1:0] frame_stat;

  assign buf_rd = rd_en && rd_sel;
  assign ovr    = full_q && !buf_rd;

  always_comb begin
    frame_stat         = '0;
    frame_stat[ST_PAR] = par_err;
    frame_stat[ST_FRM] = frm_err;
    frame_stat[ST_OVR] = ovr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      stat_q  <= '0;
      full_q  <= 1'b0;
      ierr_q  <= 1'b0;
      idone_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      ierr_q  <= 1'b0;
      pend_q  <= 1'b0;
      idone_q <= pend_q;
      if (buf_rd) begin
        stat_q <= '0;
        full_q <= 1'b0;
      end
      if (ev_par && par_err) begin
        stat_q         <= '0;
        stat_q[ST_PAR] <= 1'b1;
        ierr_q         <= 1'b1;
      end
      if (ev_done) begin
        buf_q  <= data;
        full_q <= 1'b1;
        stat_q <= frame_stat;
        ierr_q <= frm_err || ovr;
        pend_q <= !(err_mask && (|frame_stat));
      end
    end
  end

  assign rd_data  = rd_sel ? buf_q : {{(DATA_W-STAT_W){1'b0}}, stat_q};
  assign buf_full = full_q;
  assign status   = stat_q;
  assign irq_err  = ierr_q;
  assign irq_done = idone_q;
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rxd,
  input  logic [1:0]        par_mode,
  input  logic              err_mask,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              irq_err,
  output logic              irq_done
);
  logic              rx_s;
  logic              ev_par, ev_done, par_err, frm_err;
  logic [DATA_W-1:0] rx_byte;
  logic [STAT_W-1:0] status_w;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
  );

  uart_rx_sampler #(.TICKS_PER_BIT(TICKS_PER_BIT), .DATA_W(DATA_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rx(rx_s), .par_mode(par_mode),
    .ev_par(ev_par), .ev_done(ev_done), .par_err(par_err), .frm_err(frm_err),
    .data(rx_byte)
  );

  uart_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ev_par(ev_par), .ev_done(ev_done),
    .par_err(par_err), .frm_err(frm_err), .data(rx_byte), .err_mask(err_mask),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .buf_full(buf_full),
    .status(status_w), .irq_err(irq_err), .irq_done(irq_done)
  );
endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_par,
  input logic       ev_done,
  input logic       par_err,
  input logic       frm_err,
  input logic       rd_en,
  input logic       rd_sel,
  input logic       err_mask,
  input logic       buf_full,
  input logic [2:0] status,
  input logic       irq_err,
  input logic       irq_done
);
  p_done_sets_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> buf_full);

  p_parity_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_par && par_err) |=> (status == 3'b100) && irq_err);

  p_frame_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && frm_err) |=> status[1] && irq_err);

  p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && buf_full && !(rd_en && rd_sel)) |=> status[0] && buf_full && irq_err);

  p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_err && irq_done));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_err && err_mask) |=> !irq_done);

  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && !ev_done && !ev_par) |=> (status == 3'b000) && !buf_full);

  p_status_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !ev_done && !ev_par) |=> $stable(status) && $stable(buf_full));
endmodule

bind uart_rx_err uart_rx_err_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_par(ev_par), .ev_done(ev_done),
  .par_err(par_err), .frm_err(frm_err), .rd_en(rd_en), .rd_sel(rd_sel),
  .err_mask(err_mask), .buf_full(buf_full), .status(status_w),
  .irq_err(irq_err), .irq_done(irq_done)
);

// File: tb/uart_rx_err_bench.sv
module uart_rx_err_bench;
  localparam int TPB      = 16;
  localparam int DW       = 8;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = TPB * TICK_DIV;
  localparam int NVEC     = 12;

  // {data[16:9], mode[8:7], mask[6], bad_parity[5], bad_stop[4], keep_buffer[3], exp_status[2:0]}
  localparam logic [16:0] VEC [0:NVEC-1] = '{
    {8'hA5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000},
    {8'h3C, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000},
    {8'h3C, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b100},
    {8'h7E, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000},
    {8'h81, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'b100},
    {8'h55, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000},
    {8'h0F, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b010},
    {8'hF0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001},
    {8'h99, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'b100},
    {8'h12, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b010},
    {8'h34, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001},
    {8'h56, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 3'b110}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_tick = 1'b0;
  logic          rxd = 1'b1;
  logic [1:0]    par_mode = 2'd0;
  logic          err_mask = 1'b0;
  logic          rd_en = 1'b0;
  logic          rd_sel = 1'b0;
  logic [DW-1:0] rd_data;
  logic          buf_full, irq_err, irq_done;

  int checks = 0, failures = 0;
  int cyc = 0, err_n = 0, done_n = 0, last_err = 0, last_done = 0, div = 0;
  bit finished = 1'b0;

  uart_rx_err #(.TICKS_PER_BIT(TPB), .DATA_W(DW), .SYNC_STAGES(2)) u_uart_rx_err (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .par_mode(par_mode), .err_mask(err_mask), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .buf_full(buf_full), .irq_err(irq_err), .irq_done(irq_done)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    div = (div == TICK_DIV - 1) ? 0 : div + 1;
    sample_tick = (div == 0);
    if (rst_n && irq_err)  begin err_n  = err_n + 1;  last_err  = cyc; end
    if (rst_n && irq_done) begin done_n = done_n + 1; last_done = cyc; end
    if (cyc > 150000 && !finished) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 150000)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic sel, input logic strobe, output logic [DW-1:0] v);
    @(negedge clk);
    rd_sel = sel;
    rd_en  = strobe;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic drive_bit(input logic b, input int clocks);
    rxd = b;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input logic [1:0] mode,
                            input logic bad_par, input logic bad_stop);
    logic p;
    @(negedge clk);
    drive_bit(1'b0, BIT_CLK);
    for (int i = 0; i < DW; i++) drive_bit(d[i], BIT_CLK);
    if (mode != 2'd0) begin
      p = (mode == 2'd2) ? ~(^d) : (^d);
      drive_bit(p ^ bad_par, BIT_CLK);
    end
    if (bad_stop) begin
      drive_bit(1'b0, (BIT_CLK * 3) / 4);
      drive_bit(1'b1, BIT_CLK * 2);
    end else begin
      drive_bit(1'b1, BIT_CLK * 2);
    end
  endtask

  initial begin
    logic [DW-1:0] v;
    logic [2:0]    es;
    int            e0, d0, exp_err, exp_done;

    repeat (4) @(negedge clk);
    // R11: reset state, before reset is released
    chk("R11 irq_err in reset", {31'd0, irq_err}, 32'd0);
    chk("R11 irq_done in reset", {31'd0, irq_done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 buf_full after reset", {31'd0, buf_full}, 32'd0);
    read_reg(1'b0, 1'b0, v);
    chk("R11 status after reset", {24'd0, v}, 32'd0);
    read_reg(1'b1, 1'b0, v);
    chk("R11 buffer after reset", {24'd0, v}, 32'd0);

    for (int k = 0; k < NVEC; k++) begin
      par_mode = VEC[k][8:7];
      err_mask = VEC[k][6];
      es       = VEC[k][2:0];
      if (!VEC[k][3]) read_reg(1'b1, 1'b1, v);
      e0 = err_n;
      d0 = done_n;
      send_frame(VEC[k][16:9], VEC[k][8:7], VEC[k][5], VEC[k][4]);
      repeat (16) @(negedge clk);
      read_reg(1'b0, 1'b0, v);
      chk($sformatf("R2 R3 R4 R9 status of vector %0d", k), {24'd0, v}, {29'd0, es});
      read_reg(1'b1, 1'b0, v);
      chk($sformatf("R1 R4 buffer of vector %0d", k), {24'd0, v}, {24'd0, VEC[k][16:9]});
      chk($sformatf("R1 R4 buf_full of vector %0d", k), {31'd0, buf_full}, 32'd1);
      exp_err  = int'(es[2]) + int'(es[1] | es[0]);
      exp_done = (VEC[k][6] && (es != 3'b000)) ? 0 : 1;
      chk($sformatf("R5 error pulses of vector %0d", k), err_n - e0, exp_err);
      chk($sformatf("R6 R7 done pulses of vector %0d", k), done_n - d0, exp_done);
      if (exp_err > 0 && exp_done > 0)
        chk($sformatf("R6 error before done in vector %0d", k),
            {31'd0, last_err < last_done}, 32'd1);
    end

    // R8: status read has no side effect, buffer read clears status and buf_full
    par_mode = 2'd0;
    err_mask = 1'b0;
    read_reg(1'b1, 1'b1, v);
    send_frame(8'hC3, 2'd0, 1'b0, 1'b1);
    repeat (16) @(negedge clk);
    read_reg(1'b0, 1'b1, v);
    chk("R8 first status read", {24'd0, v}, 32'h02);
    read_reg(1'b0, 1'b1, v);
    chk("R8 second status read unchanged", {24'd0, v}, 32'h02);
    chk("R8 buf_full kept by status read", {31'd0, buf_full}, 32'd1);
    read_reg(1'b1, 1'b1, v);
    chk("R8 buffer content", {24'd0, v}, 32'hC3);
    chk("R8 buf_full cleared by buffer read", {31'd0, buf_full}, 32'd0);
    read_reg(1'b0, 1'b0, v);
    chk("R8 status cleared by buffer read", {24'd0, v}, 32'h00);

    // R10: a short start glitch is ignored
    e0 = err_n;
    d0 = done_n;
    @(negedge clk);
    drive_bit(1'b0, 3 * TICK_DIV);
    drive_bit(1'b1, BIT_CLK * 4);
    chk("R10 no done pulse from glitch", done_n - d0, 0);
    chk("R10 no error pulse from glitch", err_n - e0, 0);
    chk("R10 buf_full stays clear", {31'd0, buf_full}, 32'd0);
    read_reg(1'b0, 1'b0, v);
    chk("R10 status stays clear", {24'd0, v}, 32'h00);
    send_frame(8'h6B, 2'd0, 1'b0, 1'b0);
    repeat (16) @(negedge clk);
    read_reg(1'b1, 1'b0, v);
    chk("R10 R1 frame after glitch", {24'd0, v}, 32'h6B);
    chk("R10 done after glitch frame", done_n - d0, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule